// File: doc/BRIEF.md
# UART Byte Register Front End with Transmit Status

This block is the byte-wide register side of a simple UART. One data address serves both directions, and the access direction picks the path. A write places a byte in the transmit holding FIFO. A read takes the oldest byte out of the receive FIFO. A second address returns a line status byte. That byte shows whether received data is waiting and whether an overrun has occurred. It also shows two transmit conditions apart from each other: "holding FIFO empty", and "whole transmitter empty", which means the shift register is also idle.

Behind the transmit FIFO, a shift register serialises each byte as 8N1 frames, least significant bit first. Each bit lasts `CLKS_PER_BIT` clocks. A matching receiver deserialises the incoming line into the receive FIFO. The shift registers have no address. The two paths share no state, so traffic in one direction never disturbs the other.

Top module: `uart_regfront`

## Requirements
- R1: A write to the data address (0) pushes the byte into the transmit FIFO. Bytes leave on `tx_line` in write order. Each frame is one low start bit, eight data bits LSB first and one high stop bit, and each bit lasts `CLKS_PER_BIT` clocks. The line is high whenever nothing is being sent.
- R2: A read of the data address returns the oldest received byte and removes it from the receive FIFO. A data read while the receive FIFO is empty returns 0 and changes no state.
- R3: Each FIFO holds `FIFO_DEPTH` (16) bytes. One further transmit byte can sit in the shift register. A write while the transmit FIFO is full is ignored, and the byte is never sent.
- R4: Status address (1), bit 0 is 1 exactly when the receive FIFO holds at least one byte.
- R5: Status bit 5 is 1 when the transmit FIFO is empty. Status bit 6 is 1 only when the transmit FIFO is empty and the shift register is idle, so it is 0 while a frame is on the line. Bits 7, 4, 3 and 2 read 0.
- R6: A byte that completes while the receive FIFO is full is discarded and sets status bit 1. The status read that sees bit 1 set also clears it, so the next status read returns 0 in bit 1.
- R7: The paths are independent. Transmit writes do not change receive FIFO contents. Received bytes do not change the transmit FIFO. Writes to any address other than 0 reach neither path.
- R8: The receiver checks that the start bit is still low at half a bit period. It samples every data bit and the stop bit near mid-bit. A frame whose stop bit is low is dropped without entering the receive FIFO.
- R9: After reset the status byte reads 0x60, `tx_line` is high and both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address: 0 data, 1 line status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current access (combinational) |
| tx_line | output | 1 | Serial transmit output, idle high |
| rx_line | input | 1 | Serial receive input, idle high |

## Verification
A single isolated transmit byte and a single received byte establish the frame format, the byte order and how each status bit moves. Transmit writes run concurrently with incoming serial frames, which would expose any coupling of the two FIFOs through the shared data address. A seventeenth transmit byte written while the shifter is busy and a seventeenth received byte sent with no reads separate correct full-FIFO dropping from wrap or overwrite faults. The second case also shows overrun being set and cleared. A frame with a low stop bit, followed by a good frame, shows that framing rejection does not leave the receiver stuck.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_START,
        SER_DATA,
        SER_STOP
    } ser_state_e;

    typedef struct packed {
        logic       rsvd7;
        logic       xmit_idle;
        logic       hold_empty;
        logic [2:0] rsvd;
        logic       overrun;
        logic       rx_ready;
    } line_status_t;

    function automatic line_status_t make_status(
        input logic rx_ready,
        input logic overrun,
        input logic hold_empty,
        input logic shifter_busy
    );
        line_status_t s;
        s            = '0;
        s.rx_ready   = rx_ready;
        s.overrun    = overrun;
        s.hold_empty = hold_empty;
        s.xmit_idle  = hold_empty && !shifter_busy;
        return s;
    endfunction

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_rf_tx.sv
module uart_rf_tx
    import uart_rf_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    localparam int CNTW        = $clog2(CLKS_PER_BIT),
    localparam int IDXW        = $clog2(DATA_W)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  have_data,
    input  byte_t data,
    output logic  take,
    output logic  line,
    output logic  busy
);

    ser_state_e      state;
    logic [CNTW-1:0] cnt;
    logic [IDXW-1:0] idx;
    byte_t           sh;
    logic            last;

    assign last = (cnt == CNTW'(CLKS_PER_BIT - 1));
    assign take = (state == SER_IDLE) && have_data;
    assign busy = (state != SER_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SER_IDLE;
            line  <= 1'b1;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
        end else begin
            case (state)
                SER_IDLE: begin
                    if (have_data) begin
                        sh    <= data;
                        line  <= 1'b0;
                        cnt   <= '0;
                        state <= SER_START;
                    end
                end
                SER_START: begin
                    if (last) begin
                        cnt   <= '0;
                        idx   <= '0;
                        line  <= sh[0];
                        state <= SER_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SER_DATA: begin
                    if (last) begin
                        cnt <= '0;
                        if (idx == IDXW'(DATA_W - 1)) begin
                            line  <= 1'b1;
                            state <= SER_STOP;
                        end else begin
                            idx  <= idx + 1'b1;
                            sh   <= sh >> 1;
                            line <= sh[1];
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (last) begin
                        cnt   <= '0;
                        state <= SER_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_rf_rx.sv
module uart_rf_rx
    import uart_rf_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    localparam int CNTW        = $clog2(CLKS_PER_BIT),
    localparam int IDXW        = $clog2(DATA_W),
    localparam int HALF        = CLKS_PER_BIT / 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  line_in,
    output logic  valid,
    output byte_t data
);

    ser_state_e      state;
    logic [CNTW-1:0] cnt;
    logic [IDXW-1:0] idx;
    logic [1:0]      sync;
    logic            s;
    logic            last;

    assign s    = sync[1];
    assign last = (cnt == CNTW'(CLKS_PER_BIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= 2'b11;
            state <= SER_IDLE;
            cnt   <= '0;
            idx   <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            sync  <= {sync[0], line_in};
            valid <= 1'b0;
            case (state)
                SER_IDLE: begin
                    cnt <= '0;
                    if (!s) state <= SER_START;
                end
                SER_START: begin
                    if (cnt == CNTW'(HALF - 1)) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= s ? SER_IDLE : SER_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SER_DATA: begin
                    if (last) begin
                        cnt  <= '0;
                        data <= {s, data[DATA_W-1:1]};
                        if (idx == IDXW'(DATA_W - 1)) state <= SER_STOP;
                        else                           idx   <= idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (last) begin
                        cnt   <= '0;
                        valid <= s;
                        state <= SER_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int FIFO_DEPTH   = 16,
    parameter int ADDR_W       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              tx_line,
    input  logic              rx_line
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(1);

    logic             wr_data, rd_data, rd_status;
    byte_t            tx_head, rx_head, rx_byte;
    logic             tx_empty, tx_full, tx_take, tx_busy;
    logic             rx_empty, rx_full, rx_valid;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic             overrun;
    line_status_t     status;

    assign wr_data   = bus_sel &&  bus_wr && (bus_addr == A_DATA);
    assign rd_data   = bus_sel && !bus_wr && (bus_addr == A_DATA);
    assign rd_status = bus_sel && !bus_wr && (bus_addr == A_STATUS);

    uart_rf_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(wr_data), .din(bus_wdata),
        .pop(tx_take), .dout(tx_head),
        .empty(tx_empty), .full(tx_full), .count(tx_count)
    );

    uart_rf_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst(rst),
        .have_data(!tx_empty), .data(tx_head),
        .take(tx_take), .line(tx_line), .busy(tx_busy)
    );

    uart_rf_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst(rst),
        .line_in(rx_line), .valid(rx_valid), .data(rx_byte)
    );

    uart_rf_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_valid), .din(rx_byte),
        .pop(rd_data), .dout(rx_head),
        .empty(rx_empty), .full(rx_full), .count(rx_count)
    );

    always_ff @(posedge clk) begin
        if (rst)                        overrun <= 1'b0;
        else if (rx_valid && rx_full)   overrun <= 1'b1;
        else if (rd_status)             overrun <= 1'b0;
    end

    assign status = make_status(!rx_empty, overrun, tx_empty, tx_busy);

    always_comb begin
        if (bus_addr == A_DATA)        bus_rdata = rx_empty ? 8'h00 : rx_head;
        else if (bus_addr == A_STATUS) bus_rdata = status;
        else                           bus_rdata = 8'h00;
    end

endmodule

// File: rtl/uart_regfront_checker.sv
module uart_regfront_checker #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_data,
    input logic          rd_data,
    input logic          rd_status,
    input logic          tx_full,
    input logic          tx_take,
    input logic [CW-1:0] tx_count,
    input logic          rx_valid,
    input logic          rx_full,
    input logic [CW-1:0] rx_count,
    input logic          overrun,
    input logic [7:0]    status_b,
    input logic          tx_line
);

    p_line_idle_r1: assert property (@(posedge clk) disable iff (rst)
        status_b[6] |-> tx_line);

    p_idle_implies_hold_empty_r5: assert property (@(posedge clk) disable iff (rst)
        status_b[6] |-> status_b[5]);

    p_overrun_set_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_full) |=> overrun);

    p_overrun_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !(rx_valid && rx_full)) |=> !overrun);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_data && tx_full && !tx_take) |=> (tx_count == $past(tx_count)));

    p_rx_untouched_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !rx_valid && !rd_data) |=> $stable(rx_count));

    p_tx_untouched_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !wr_data && !tx_take) |=> $stable(tx_count));

endmodule

bind uart_regfront uart_regfront_checker #(.CW(CNT_W)) u_chk (
    .clk(clk), .rst(rst),
    .wr_data(wr_data), .rd_data(rd_data), .rd_status(rd_status),
    .tx_full(tx_full), .tx_take(tx_take), .tx_count(tx_count),
    .rx_valid(rx_valid), .rx_full(rx_full), .rx_count(rx_count),
    .overrun(overrun), .status_b(status), .tx_line(tx_line)
);

// File: tb/uart_regfront_test.sv
module uart_regfront_test;

    localparam int CPB   = 8;
    localparam int DEPTH = 16;
    localparam int AW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          tx_line;
    logic          rx_line = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] tx_exp[$];
    logic [7:0] tx_got[$];
    logic [7:0] rx_exp[$];

    always #2.5 clk = ~clk;

    uart_regfront #(.CLKS_PER_BIT(CPB), .FIFO_DEPTH(DEPTH), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_line(tx_line), .rx_line(rx_line)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    // Serial monitor on the transmit line: decodes 8N1 frames, LSB first
    initial begin
        logic [7:0] b;
        forever begin
            @(posedge clk);
            if (!rst && tx_line === 1'b0) begin
                repeat (CPB / 2) @(posedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (CPB) @(posedge clk);
                    b[i] = tx_line;
                end
                repeat (CPB) @(posedge clk);
                check(tx_line === 1'b1, "R1 stop bit", int'(tx_line), 1);
                tx_got.push_back(b);
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic send_serial(input logic [7:0] b, input logic stop_val);
        @(negedge clk);
        rx_line = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (CPB) @(negedge clk);
        end
        rx_line = stop_val;
        repeat (CPB) @(negedge clk);
        rx_line = 1'b1;
        repeat (CPB) @(negedge clk);
        if (stop_val) rx_exp.push_back(b);
    endtask

    task automatic tx_send(input logic [7:0] b);
        bus_write(AW'(0), b);
        tx_exp.push_back(b);
    endtask

    task automatic wait_tx_drain();
        logic [7:0] s;
        for (int i = 0; i < 4000; i++) begin
            bus_read(AW'(1), s);
            if (s[6]) break;
        end
        repeat (CPB) @(negedge clk);
    endtask

    task automatic compare_tx(input string tag);
        check(tx_got.size() == tx_exp.size(), tag, tx_got.size(), tx_exp.size());
        for (int i = 0; i < tx_exp.size() && i < tx_got.size(); i++)
            check(tx_got[i] == tx_exp[i], tag, tx_got[i], tx_exp[i]);
        tx_got.delete();
        tx_exp.delete();
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] s;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R9 reset state
        bus_read(AW'(1), s);
        check(s == 8'h60, "R9 status after reset", s, 8'h60);
        check(tx_line === 1'b1, "R9 tx_line after reset", int'(tx_line), 1);

        // R2 empty data read
        bus_read(AW'(0), d);
        check(d == 8'h00, "R2 empty read value", d, 0);
        bus_read(AW'(1), s);
        check(s == 8'h60, "R2 status unchanged by empty read", s, 8'h60);

        // R1/R5 single byte out
        tx_send(8'hA5);
        repeat (4) @(negedge clk);
        bus_read(AW'(1), s);
        check(s[5] == 1'b1, "R5 holding empty while shifting", s[5], 1);
        check(s[6] == 1'b0, "R5 transmitter busy", s[6], 0);
        check(tx_line === 1'b0, "R1 start bit low", int'(tx_line), 0);
        wait_tx_drain();
        compare_tx("R1 single byte");
        bus_read(AW'(1), s);
        check(s == 8'h60, "R5 idle status", s, 8'h60);

        // R4/R2 single byte in
        send_serial(8'h3C, 1'b1);
        bus_read(AW'(1), s);
        check(s == 8'h61, "R4 data ready", s, 8'h61);
        bus_read(AW'(0), d);
        check(d == rx_exp.pop_front(), "R2 read byte", d, 8'h3C);
        bus_read(AW'(1), s);
        check(s[0] == 1'b0, "R4 data ready cleared", s[0], 0);

        // R7 concurrent traffic in both directions, plus an unmapped write
        fork
            begin
                send_serial(8'h81, 1'b1);
                send_serial(8'h7E, 1'b1);
            end
            begin
                tx_send(8'h11);
                bus_write(AW'(2), 8'hEE);
                tx_send(8'h22);
                repeat (30) @(negedge clk);
                tx_send(8'h33);
            end
        join
        wait_tx_drain();
        compare_tx("R7 tx order under rx traffic");
        for (int i = 0; i < 2; i++) begin
            bus_read(AW'(0), d);
            check(d == rx_exp[0], "R7 rx bytes under tx traffic", d, rx_exp[0]);
            void'(rx_exp.pop_front());
        end
        bus_read(AW'(1), s);
        check(s == 8'h60, "R7 both paths empty", s, 8'h60);

        // R3 transmit FIFO full
        tx_send(8'h40);
        repeat (3) @(negedge clk);
        for (int i = 1; i <= 16; i++) tx_send(8'h40 + 8'(i));
        bus_read(AW'(1), s);
        check(s[5] == 1'b0, "R3 holding not empty when full", s[5], 0);
        bus_write(AW'(0), 8'hC9);
        wait_tx_drain();
        compare_tx("R3 full write ignored");

        // R6 receive overrun
        for (int i = 0; i < 17; i++) send_serial(8'h90 + 8'(i), 1'b1);
        void'(rx_exp.pop_back());
        bus_read(AW'(1), s);
        check(s[1:0] == 2'b11, "R6 overrun set", s[1:0], 3);
        bus_read(AW'(1), s);
        check(s[1] == 1'b0, "R6 overrun cleared by status read", s[1], 0);
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(AW'(0), d);
            check(d == rx_exp[0], "R3 rx fifo depth contents", d, rx_exp[0]);
            void'(rx_exp.pop_front());
        end
        bus_read(AW'(1), s);
        check(s == 8'h60, "R3 rx fifo drained", s, 8'h60);

        // R8 framing reject then recovery
        send_serial(8'h55, 1'b0);
        bus_read(AW'(1), s);
        check(s[0] == 1'b0, "R8 bad stop dropped", s[0], 0);
        send_serial(8'h66, 1'b1);
        bus_read(AW'(0), d);
        check(d == 8'h66, "R8 good frame after bad", d, 8'h66);
        check(tx_got.size() == 0, "R7 no stray tx", tx_got.size(), 0);

        finish_run();
    end

endmodule